// File: doc/BRIEF.md
# Bidirectional GPIO Port with Snapshot Change Interrupt

An eight-pin general-purpose I/O port for a small microcontroller bus. Software sets, per pin, whether the pin is driven or floated. It writes the value to drive into an output latch. It reads the pin levels back through a port register. The pad side receives the latch value, an output enable per pin, a pull-up enable per pin, and returns the raw pin levels. These levels pass through a two-flop synchronizer before any use. An analog mask forces chosen pins to read as zero.

The upper four pins feed a change detector. The reference for that detector is a snapshot, not the previous clock's value. The snapshot is taken whenever software reads or writes the port register. A participating pin is one that is a digital input. If any participating pin differs from its snapshot, the change flag is set. The flag stays set for as long as the difference exists. The flag also drives a wake request.

Software services the interrupt in three steps: access the port register, wait one cycle, then write 0 to the flag bit. A single active-low control bit turns on weak pull-ups for every pin configured as an input. Reset turns the pull-ups off.

Top module: `gpio_chg_port`

Register map (3-bit address):

| Address | Register | Content |
|---------|----------|---------|
| 0 | port | Read: pin levels. Write: sets the output latch and takes a new snapshot. |
| 1 | latch | Output latch, read and write. |
| 2 | direction | Direction bits; 1 means input. |
| 3 | control | Bit 0 is the change flag. Bit 7 is the pull-up disable (active low enable). |
| 4 | analog mask | A 1 makes that pin analog. |

Unmapped addresses read as 0.

## Requirements
- R1: After reset, the registers and pads are in this state:
  - direction reads 0xFF, latch reads 0x00 and the analog mask reads 0x13 (pins 4, 1 and 0 analog);
  - control reads 0x80 (pull-ups off, flag clear);
  - padOe, padPull and wakeReq are all 0.
- R2: For each pin i, a direction bit of 0 drives the pin: padOe[i]=1 and padOut[i] equals latch bit i. A direction bit of 1 gives padOe[i]=0.
- R3: A read at address 1 returns the latch contents, not the pin level. This holds for an input pin whose latch bit differs from its pin.
- R4: A read at address 0 returns the pin levels after two synchronizer flops. Any pin whose analog-mask bit is 1 reads 0. Read data appears on rdData one cycle after the read strobe and holds until the next read.
- R5: padPull[i] is 1 only when control bit 7 is 0 and pin i is an input. A pin configured as an output never has its pull-up on.
- R6: Only pins 7..4 take part in change detection, and only while they are digital inputs. The flag (control bit 0) sets when such a pin's read value differs from the snapshot. Changes on pins 3..0, or on output pins, never set it.
- R7: While a mismatch exists, writing 0 to control bit 0 has no lasting effect, and the flag reads 1. A set condition in the same cycle as a clear wins.
- R8: A read or write of address 0 recaptures the snapshot. A clear written in the next cycle then succeeds, if the pins are unchanged.
- R9: A write at address 0 also loads the output latch.
- R10: wakeReq is high exactly when the change flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write enable |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| padIn | input | 8 | Raw pin levels from the pads |
| padOut | output | 8 | Output latch value to the pads |
| padOe | output | 8 | Per-pin output enable |
| padPull | output | 8 | Per-pin weak pull-up enable |
| chgIrq | output | 1 | Change interrupt flag |
| wakeReq | output | 1 | Wake-from-sleep request |

## Verification
The bench toggles lower pins, upper pins and upper pins that have been turned into outputs, and checks the flag each time. A detector that did not restrict itself to digital inputs on the upper nibble would flag the wrong pins. The bench also tries to clear the flag with no port access. A design that let the clear win would drop an interrupt that is still pending. The bench then clears the flag in the cycle right after a port read, and again after a port write. A design that never refreshed the snapshot, or refreshed it one cycle too late, would leave the flag stuck. An input pin whose latch bit differs from its level tells a latch readback apart from a pin readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 3'd0,
    REG_LAT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_CTRL = 3'd3,
    REG_ANA  = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrPort;
    logic    wrLat;
    logic    wrDir;
    logic    wrAna;
    logic    rdPort;
    logic    rdEn;
    regSel_e rdSel;
  } dpStrobe_t;
endpackage

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [WIDTH-1:0]    busWdata,
  input  logic                mismatch,
  output dpStrobe_t           stb,
  output logic                chgFlag,
  output logic                pullN
);
  regSel_e sel;
  logic    wrCtrl;

  assign sel = regSel_e'(busAddr);

  always_comb begin
    stb        = '0;
    wrCtrl     = 1'b0;
    stb.rdEn   = busRd;
    stb.rdSel  = sel;
    stb.rdPort = busRd && (sel == REG_PORT);
    if (busWr) begin
      case (sel)
        REG_PORT: stb.wrPort = 1'b1;
        REG_LAT:  stb.wrLat  = 1'b1;
        REG_DIR:  stb.wrDir  = 1'b1;
        REG_CTRL: wrCtrl     = 1'b1;
        REG_ANA:  stb.wrAna  = 1'b1;
        default:  ;
      endcase
    end
  end

  // a pending mismatch overrides a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chgFlag <= 1'b0;
      pullN   <= 1'b1;
    end else begin
      if (mismatch)
        chgFlag <= 1'b1;
      else if (wrCtrl && !busWdata[0])
        chgFlag <= 1'b0;
      if (wrCtrl)
        pullN <= busWdata[WIDTH-1];
    end
  end
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned CHG_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] ANA_RESET = 8'h13
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic             chgFlag,
  input  logic             pullN,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPull,
  output logic             mismatch
);
  localparam int unsigned CHG_W = WIDTH - CHG_LO;

  logic [WIDTH-1:0] syncPipe [SYNC_STAGES];
  logic [WIDTH-1:0] syncIn, portView, latReg, dirReg, anaReg, rdNext;
  logic [CHG_W-1:0] snapReg, diffBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
    end else begin
      syncPipe[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign syncIn   = syncPipe[SYNC_STAGES-1];
  assign portView = syncIn & ~anaReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg  <= '0;
      dirReg  <= '1;
      anaReg  <= ANA_RESET;
      snapReg <= '0;
    end else begin
      if (stb.wrPort || stb.wrLat) latReg <= busWdata;
      if (stb.wrDir)               dirReg <= busWdata;
      if (stb.wrAna)               anaReg <= busWdata;
      if (stb.wrPort || stb.rdPort) snapReg <= portView[WIDTH-1:CHG_LO];
    end
  end

  // compare only digital inputs of the upper group against the snapshot
  assign diffBits = (portView[WIDTH-1:CHG_LO] ^ snapReg) & dirReg[WIDTH-1:CHG_LO];
  assign mismatch = |diffBits;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      assign padOut[i]  = latReg[i];
      assign padOe[i]   = ~dirReg[i];
      assign padPull[i] = dirReg[i] & ~pullN;
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      REG_PORT: rdNext = portView;
      REG_LAT:  rdNext = latReg;
      REG_DIR:  rdNext = dirReg;
      REG_CTRL: begin
        rdNext[WIDTH-1] = pullN;
        rdNext[0]       = chgFlag;
      end
      REG_ANA:  rdNext = anaReg;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned CHG_LO      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] ANA_RESET = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPull,
  output logic              chgIrq,
  output logic              wakeReq
);
  dpStrobe_t stb;
  logic      chgFlag, pullN, mismatch;

  gpio_ctl #(.WIDTH(WIDTH)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .mismatch(mismatch), .stb(stb), .chgFlag(chgFlag),
    .pullN(pullN)
  );

  gpio_dp #(
    .WIDTH(WIDTH), .CHG_LO(CHG_LO), .SYNC_STAGES(SYNC_STAGES), .ANA_RESET(ANA_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .padIn(padIn),
    .chgFlag(chgFlag), .pullN(pullN), .rdData(rdData), .padOut(padOut),
    .padOe(padOe), .padPull(padPull), .mismatch(mismatch)
  );

  assign chgIrq  = chgFlag;
  assign wakeReq = chgFlag;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic             busWr,
  input logic [WIDTH-1:0] busWdata,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padPull,
  input logic             chgIrq,
  input logic             wakeReq,
  input logic             mismatch
);
  assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (padPull & padOe) == '0);

  assert_wake_R10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq == chgIrq);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> chgIrq);

  assert_clear_ok_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd3 && !busWdata[0] && !mismatch) |=> !chgIrq);

  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chgIrq) |-> $past(mismatch));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .padOe(padOe), .padPull(padPull), .chgIrq(chgIrq), .wakeReq(wakeReq),
  .mismatch(mismatch)
);

// File: tb/gpio_chg_port_bench.sv
module gpio_chg_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] rdData, padIn, padOut, padOe, padPull, ext = '0;
  logic       chgIrq, wakeReq;
  int         total = 0, bad = 0;
  logic       pullBit = 1'b1;

  always #2 clk = ~clk;

  // pad model: driven pins show the latch, floating pins show the external level
  assign padIn = (padOe & padOut) | (~padOe & ext);

  gpio_chg_port u_gpio_chg_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .rdData(rdData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padPull(padPull), .chgIrq(chgIrq), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = rdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // port read then clear in the very next cycle
  task automatic resync();
    logic [7:0] d;
    busRead(3'd0, d);
    busWrite(3'd3, {pullBit, 7'b0});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    busRead(3'd2, d); check("R1 dir", d, 8'hFF);
    busRead(3'd1, d); check("R1 latch", d, 8'h00);
    busRead(3'd4, d); check("R1 analog", d, 8'h13);
    busRead(3'd3, d); check("R1 ctrl", d, 8'h80);
    check("R1 padOe", padOe, 8'h00);
    check("R1 padPull", padPull, 8'h00);
    check("R1 wake", {7'b0, wakeReq}, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] d;
    busWrite(3'd4, 8'h00);
    busWrite(3'd1, 8'hA5);
    busWrite(3'd2, 8'h0F);
    ext = 8'h06;
    settle();
    check("R2 padOe", padOe, 8'hF0);
    check("R2 padOut", padOut, 8'hA5);
    busRead(3'd0, d); check("R4 port mixed", d, 8'hA6);
    busWrite(3'd2, 8'hFF);
    ext = 8'h00;
    settle();
    check("R2 padOe input", padOe, 8'h00);
    resync();
  endtask

  task automatic t_latch();
    logic [7:0] d;
    busWrite(3'd1, 8'hFF);
    settle();
    busRead(3'd1, d); check("R3 latch read", d, 8'hFF);
    busRead(3'd0, d); check("R3 port read", d, 8'h00);
  endtask

  task automatic t_analog();
    logic [7:0] d;
    busWrite(3'd4, 8'h13);
    ext = 8'hFF;
    settle();
    busRead(3'd0, d); check("R4 analog mask", d, 8'hEC);
    busWrite(3'd4, 8'h00);
    ext = 8'h00;
    settle();
    resync();
  endtask

  task automatic t_pull();
    busWrite(3'd2, 8'h0F);
    pullBit = 1'b0;
    busWrite(3'd3, 8'h00);
    check("R5 pull on inputs", padPull, 8'h0F);
    pullBit = 1'b1;
    busWrite(3'd3, 8'h80);
    check("R5 pull off", padPull, 8'h00);
    busWrite(3'd2, 8'hFF);
    settle();
    resync();
  endtask

  task automatic t_change();
    logic [7:0] d;
    busWrite(3'd1, 8'h00);
    ext = 8'h04;
    settle();
    check("R6 lower pin ignored", {7'b0, chgIrq}, 8'h00);
    ext = 8'h44;
    settle();
    check("R6 upper pin flags", {7'b0, chgIrq}, 8'h01);
    check("R10 wake", {7'b0, wakeReq}, 8'h01);
    busRead(3'd3, d); check("R6 ctrl flag", d, 8'h81);
    resync();
    check("R8 clear after read", {7'b0, chgIrq}, 8'h00);
    check("R10 wake low", {7'b0, wakeReq}, 8'h00);
    busWrite(3'd2, 8'hBF);
    settle();
    check("R6 output pin excluded", {7'b0, chgIrq}, 8'h00);
    busWrite(3'd2, 8'hFF);
    settle();
    resync();
  endtask

  task automatic t_persist();
    logic [7:0] d;
    ext = ext ^ 8'h80;
    settle();
    busWrite(3'd3, 8'h80);
    busRead(3'd3, d); check("R7 clear blocked", d, 8'h81);
    resync();
    busRead(3'd3, d); check("R8 cleared", d, 8'h80);
  endtask

  task automatic t_port_write();
    logic [7:0] d;
    ext = ext ^ 8'h20;
    settle();
    check("R8 flag before write", {7'b0, chgIrq}, 8'h01);
    busWrite(3'd0, 8'h3C);
    busWrite(3'd3, 8'h80);
    check("R8 clear after port write", {7'b0, chgIrq}, 8'h00);
    busRead(3'd1, d); check("R9 port write latch", d, 8'h3C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_direction();
    t_latch();
    t_analog();
    t_pull();
    t_change();
    t_persist();
    t_port_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule